// File: doc/BRIEF.md
# Pair-Granular Fetch-to-Dispatch Instruction Queue

This block is a short queue between the fetch stage and the dispatch stage of a four-wide front end. Each cycle fetch may present a group of up to four instruction words. Every lane carries its own address and a lane-valid flag. The queue keeps the words in program order and shows the oldest four to the dispatcher. The dispatcher reports how many of the shown positions it consumed.

Storage is a row of pair slots. Lanes 0/1 and lanes 2/3 of a fetch group each form one pair. A pair moves toward the head only as a whole unit, and it is released only after both of its halves have been consumed. When there is not enough room for a whole group, the queue drops its ready flag so that fetch holds. A flush clears all contents in one cycle when the front end is redirected.

Top module: `instq_top`

## Requirements
- R1: After synchronous reset the queue is empty: every `disp_vld` bit is 0 and `fetch_rdy` is 1.
- R2: Capacity is `PAIRS` pair slots, which is 8 instructions by default. Lanes 2j and 2j+1 of a fetch group form one pair, and the even lane is the older half.
- R3: `fetch_rdy` is 1 exactly when at least `FETCH_W/2` pair slots were free at the start of the cycle. A group is taken in when `fetch_vld && fetch_rdy && !flush`. Otherwise the group has no effect on the contents.
- R4: Accepted words appear on the dispatch outputs one cycle after the accepting edge. Output slots 2k and 2k+1 show pair k counted from the head, with the even lane in the even slot, so the outputs are oldest-first in program order.
- R5: A `disp_take` value of N consumes output positions 0..N-1 at the clock edge. Positions in that range whose `disp_vld` is 0 are passed over. Positions beyond the stored pairs are ignored.
- R6: A pair is released only when both of its halves are consumed or are bubbles. A lone remaining valid half stays at its output slot. Surviving pairs move toward the head by the number of released pairs within the same cycle.
- R7: A lane whose valid flag is 0 is stored as a bubble and is shown with `disp_vld` 0. A pair with both lanes invalid is not stored and takes no slot.
- R8: A `flush` empties the queue at the next edge. A fetch group and a take presented in the same cycle are discarded.
- R9: When take and accept happen in the same cycle, the release is applied first and the new pairs are appended behind the surviving ones. `fetch_rdy` is still computed from the occupancy at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Front-end redirect: empty the queue |
| fetch_vld | input | 1 | A fetch group is presented |
| fetch_lane_vld | input | FETCH_W | Per-lane valid flags of the group |
| fetch_pc | input | FETCH_W x PC_W | Per-lane instruction address |
| fetch_ins | input | FETCH_W x INS_W | Per-lane instruction word |
| fetch_rdy | output | 1 | Room for a whole group |
| disp_vld | output | DISP_W | Output slot holds a live instruction |
| disp_pc | output | DISP_W x PC_W | Output slot address, oldest first |
| disp_ins | output | DISP_W x INS_W | Output slot instruction word |
| disp_take | input | clog2(DISP_W+1) | Number of leading output positions consumed |

## Verification
On every cycle, the assertions check four things: a flush empties the queue; a refused group with no take leaves the occupancy unchanged; occupancy grows by at most one group per cycle; and a single-position take on a full head pair leaves the partner in place. They also check that the head holds when nothing is taken. Other behaviour can only be shown by the bench's scenarios against its behavioural model. This covers the program order across many pairs, bubbles and dropped empty pairs, the shifting of survivors combined with same-cycle appends, and the ready threshold at each occupancy.

// File: rtl/instq_pkg.sv
package instq_pkg;

    parameter int PC_W  = 32;
    parameter int INS_W = 32;

    // One instruction position
    typedef struct packed {
        logic             vld;
        logic [PC_W-1:0]  pc;
        logic [INS_W-1:0] ins;
    } slot_t;

    // Two positions moving together; lo is the older half
    typedef struct packed {
        slot_t hi;
        slot_t lo;
    } pair_t;

    function automatic logic pair_live(pair_t p);
        return p.lo.vld | p.hi.vld;
    endfunction

endpackage

// File: rtl/instq_pack.sv
module instq_pack
    import instq_pkg::*;
#(
    parameter int FETCH_W = 4,
    localparam int FPAIRS = FETCH_W / 2,
    localparam int NW     = $clog2(FPAIRS + 1)
) (
    input  logic [FETCH_W-1:0]            lane_vld,
    input  logic [FETCH_W-1:0][PC_W-1:0]  lane_pc,
    input  logic [FETCH_W-1:0][INS_W-1:0] lane_ins,
    output pair_t [FPAIRS-1:0]            packed_pairs,
    output logic [NW-1:0]                 n_pairs
);

    // Compact the non-empty pairs of the group toward index 0
    always_comb begin
        int    n;
        pair_t p;
        n            = 0;
        packed_pairs = '0;
        for (int j = 0; j < FPAIRS; j++) begin
            p.lo = '{vld: lane_vld[2*j],   pc: lane_pc[2*j],   ins: lane_ins[2*j]};
            p.hi = '{vld: lane_vld[2*j+1], pc: lane_pc[2*j+1], ins: lane_ins[2*j+1]};
            if (pair_live(p)) begin
                packed_pairs[n] = p;
                n               = n + 1;
            end
        end
        n_pairs = NW'(n);
    end

endmodule

// File: rtl/instq_release.sv
module instq_release
    import instq_pkg::*;
#(
    parameter int PAIRS  = 4,
    parameter int DISP_W = 4,
    localparam int CNT_W  = $clog2(PAIRS + 1),
    localparam int TAKE_W = $clog2(DISP_W + 1)
) (
    input  pair_t [PAIRS-1:0] q,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [TAKE_W-1:0] take,
    output pair_t [PAIRS-1:0] q_clr,
    output logic [CNT_W-1:0]  freed
);

    always_comb begin
        int   f;
        logic go;
        q_clr = q;
        // Consume the leading positions within the occupied pairs
        for (int s = 0; s < DISP_W; s++) begin
            if ((s / 2) < int'(cnt) && s < int'(take)) begin
                if ((s % 2) == 0) q_clr[s/2].lo.vld = 1'b0;
                else              q_clr[s/2].hi.vld = 1'b0;
            end
        end
        // Release the run of drained pairs at the head
        f  = 0;
        go = 1'b1;
        for (int k = 0; k < DISP_W / 2; k++) begin
            if (go && k < int'(cnt) && !pair_live(q_clr[k])) f = f + 1;
            else                                             go = 1'b0;
        end
        freed = CNT_W'(f);
    end

endmodule

// File: rtl/instq_top.sv
module instq_top
    import instq_pkg::*;
#(
    parameter int PAIRS   = 4,
    parameter int FETCH_W = 4,
    parameter int DISP_W  = 4,
    localparam int FPAIRS = FETCH_W / 2,
    localparam int CNT_W  = $clog2(PAIRS + 1),
    localparam int TAKE_W = $clog2(DISP_W + 1),
    localparam int NW     = $clog2(FPAIRS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          fetch_vld,
    input  logic [FETCH_W-1:0]            fetch_lane_vld,
    input  logic [FETCH_W-1:0][PC_W-1:0]  fetch_pc,
    input  logic [FETCH_W-1:0][INS_W-1:0] fetch_ins,
    output logic                          fetch_rdy,
    output logic [DISP_W-1:0]             disp_vld,
    output logic [DISP_W-1:0][PC_W-1:0]   disp_pc,
    output logic [DISP_W-1:0][INS_W-1:0]  disp_ins,
    input  logic [TAKE_W-1:0]             disp_take
);

    pair_t [PAIRS-1:0]  q_r;
    logic [CNT_W-1:0]   cnt_r;

    pair_t [FPAIRS-1:0] inc;
    logic [NW-1:0]      n_in;
    pair_t [PAIRS-1:0]  q_clr;
    logic [CNT_W-1:0]   freed;
    pair_t [PAIRS-1:0]  nq;
    logic [CNT_W-1:0]   ncnt;
    logic               accept;

    instq_pack #(.FETCH_W(FETCH_W)) u_pack (
        .lane_vld     (fetch_lane_vld),
        .lane_pc      (fetch_pc),
        .lane_ins     (fetch_ins),
        .packed_pairs (inc),
        .n_pairs      (n_in)
    );

    instq_release #(.PAIRS(PAIRS), .DISP_W(DISP_W)) u_rel (
        .q     (q_r),
        .cnt   (cnt_r),
        .take  (disp_take),
        .q_clr (q_clr),
        .freed (freed)
    );

    assign fetch_rdy = int'(cnt_r) <= (PAIRS - FPAIRS);
    assign accept    = fetch_vld && fetch_rdy && !flush;

    // Shift survivors toward the head and append the incoming pairs
    always_comb begin
        int keep;
        int nin;
        keep = int'(cnt_r) - int'(freed);
        nin  = accept ? int'(n_in) : 0;
        for (int k = 0; k < PAIRS; k++) begin
            nq[k] = '0;
            if (k < keep)             nq[k] = q_clr[k + int'(freed)];
            else if ((k - keep) < nin) nq[k] = inc[k - keep];
        end
        ncnt = CNT_W'(keep + nin);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q_r   <= '0;
            cnt_r <= '0;
        end else begin
            q_r   <= nq;
            cnt_r <= ncnt;
        end
    end

    for (genvar s = 0; s < DISP_W; s++) begin : g_out
        slot_t sl;
        assign sl          = ((s % 2) == 0) ? q_r[s/2].lo : q_r[s/2].hi;
        assign disp_vld[s] = ((s / 2) < int'(cnt_r)) && sl.vld;
        assign disp_pc[s]  = sl.pc;
        assign disp_ins[s] = sl.ins;
    end

endmodule

// File: rtl/instq_chk.sv
module instq_chk
    import instq_pkg::*;
#(
    parameter int PAIRS   = 4,
    parameter int FETCH_W = 4,
    parameter int DISP_W  = 4,
    localparam int CNT_W  = $clog2(PAIRS + 1),
    localparam int TAKE_W = $clog2(DISP_W + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        flush,
    input logic                        fetch_rdy,
    input logic [DISP_W-1:0]           disp_vld,
    input logic [DISP_W-1:0][PC_W-1:0] disp_pc,
    input logic [TAKE_W-1:0]           disp_take,
    input logic [CNT_W-1:0]            cnt_r
);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (disp_vld == '0) && (cnt_r == '0));

    // R3
    refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_rdy && disp_take == '0 && !flush) |=> cnt_r == $past(cnt_r));

    // R2
    growth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !flush |=> int'(cnt_r) <= int'($past(cnt_r)) + FETCH_W / 2);

    // R6
    odd_leftover_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && disp_take == TAKE_W'(1) && disp_vld[0] && disp_vld[1])
        |=> !disp_vld[0] && disp_vld[1] && disp_pc[1] == $past(disp_pc[1]));

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && disp_take == '0 && cnt_r != '0)
        |=> $stable(disp_vld[1:0]) && disp_pc[0] == $past(disp_pc[0]));

endmodule

bind instq_top instq_chk #(.PAIRS(PAIRS), .FETCH_W(FETCH_W), .DISP_W(DISP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fetch_rdy (fetch_rdy),
    .disp_vld  (disp_vld),
    .disp_pc   (disp_pc),
    .disp_take (disp_take),
    .cnt_r     (cnt_r)
);

// File: tb/instq_top_test.sv
`timescale 1ns/1ps
module instq_top_test;

    localparam int PAIRS = 4;
    localparam int FW    = 4;
    localparam int DW    = 4;
    localparam int FP    = FW / 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               flush = 1'b0;
    logic               fetch_vld = 1'b0;
    logic [FW-1:0]      fetch_lane_vld = '0;
    logic [FW-1:0][31:0] fetch_pc = '0;
    logic [FW-1:0][31:0] fetch_ins = '0;
    logic               fetch_rdy;
    logic [DW-1:0]      disp_vld;
    logic [DW-1:0][31:0] disp_pc;
    logic [DW-1:0][31:0] disp_ins;
    logic [2:0]         disp_take = '0;

    int checks = 0;
    int fails  = 0;
    string cur = "R1";
    int unsigned base = 32'h1000;

    always #2 clk = ~clk;

    instq_top uut (
        .clk(clk), .rst(rst), .flush(flush), .fetch_vld(fetch_vld),
        .fetch_lane_vld(fetch_lane_vld), .fetch_pc(fetch_pc), .fetch_ins(fetch_ins),
        .fetch_rdy(fetch_rdy), .disp_vld(disp_vld), .disp_pc(disp_pc),
        .disp_ins(disp_ins), .disp_take(disp_take)
    );

    // Behavioural reference: a queue of pairs
    typedef struct {
        bit          v0, v1;
        logic [31:0] p0, p1, i0, i1;
    } mpair_t;
    mpair_t mq[$];
    bit     mrdy;
    mpair_t np;

    always @(posedge clk) begin
        if (rst) mq.delete();
        else begin
            mrdy = (PAIRS - mq.size()) >= FP;
            if (flush) mq.delete();
            else begin
                for (int p = 0; p < int'(disp_take); p++)
                    if (p / 2 < mq.size()) begin
                        if (p % 2 == 0) mq[p/2].v0 = 0;
                        else            mq[p/2].v1 = 0;
                    end
                while (mq.size() > 0 && !mq[0].v0 && !mq[0].v1) void'(mq.pop_front());
                if (fetch_vld && mrdy)
                    for (int j = 0; j < FP; j++)
                        if (fetch_lane_vld[2*j] || fetch_lane_vld[2*j+1]) begin
                            np.v0 = fetch_lane_vld[2*j];   np.v1 = fetch_lane_vld[2*j+1];
                            np.p0 = fetch_pc[2*j];         np.p1 = fetch_pc[2*j+1];
                            np.i0 = fetch_ins[2*j];        np.i1 = fetch_ins[2*j+1];
                            mq.push_back(np);
                        end
            end
        end
    end

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", cur, what, act, exp);
        end
    endtask

    task automatic compare();
        bit          ev;
        logic [31:0] ep, ei;
        check(fetch_rdy === ((PAIRS - mq.size()) >= FP), "R3 fetch_rdy",
              32'(fetch_rdy), 32'((PAIRS - mq.size()) >= FP));
        for (int s = 0; s < DW; s++) begin
            ev = 0; ep = '0; ei = '0;
            if (s / 2 < mq.size()) begin
                ev = (s % 2 == 0) ? mq[s/2].v0 : mq[s/2].v1;
                ep = (s % 2 == 0) ? mq[s/2].p0 : mq[s/2].p1;
                ei = (s % 2 == 0) ? mq[s/2].i0 : mq[s/2].i1;
            end
            check(disp_vld[s] === ev, $sformatf("R4 vld slot%0d", s), 32'(disp_vld[s]), 32'(ev));
            if (ev) begin
                check(disp_pc[s] === ep, $sformatf("R4 pc slot%0d", s), disp_pc[s], ep);
                check(disp_ins[s] === ei, $sformatf("R4 ins slot%0d", s), disp_ins[s], ei);
            end
        end
    endtask

    task automatic step(bit fv, logic [FW-1:0] lv, int take, bit fl);
        @(negedge clk);
        compare();
        fetch_vld      = fv;
        fetch_lane_vld = lv;
        for (int j = 0; j < FW; j++) begin
            fetch_pc[j]  = base + 32'(4 * j);
            fetch_ins[j] = (base + 32'(4 * j)) * 32'd7 + 32'h5a;
        end
        base      = base + 16;
        disp_take = 3'(take);
        flush     = fl;
    endtask

    bit done = 0;
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur = "R1";
        @(negedge clk);
        check(disp_vld == '0, "R1 empty", 32'(disp_vld), 0);
        check(fetch_rdy == 1'b1, "R1 ready", 32'(fetch_rdy), 1);
        // R2 / R3: fill to capacity, third group refused
        cur = "R2";
        for (int i = 0; i < 4; i++) step(1, 4'hF, 0, 0);
        step(0, 4'h0, 0, 0);
        check(fetch_rdy == 1'b0 && disp_vld == 4'hF, "R2 full", 32'({fetch_rdy, disp_vld}), 32'h0F);
        // R5: takes of various sizes, some past occupancy
        cur = "R5";
        step(0, 0, 4, 0); step(0, 0, 3, 0); step(0, 0, 4, 0); step(0, 0, 4, 0); step(0, 0, 4, 0);
        // R6: lone leftovers
        cur = "R6";
        step(1, 4'hF, 0, 0); step(1, 4'hF, 1, 0); step(0, 0, 1, 0); step(0, 0, 2, 0);
        step(0, 0, 3, 0); step(0, 0, 1, 0); step(0, 0, 4, 0); step(0, 0, 4, 0);
        // R7: bubbles and empty pairs
        cur = "R7";
        step(1, 4'b0101, 0, 0); step(1, 4'b1100, 0, 0); step(1, 4'b0000, 0, 0);
        step(1, 4'b0010, 2, 0); step(0, 0, 2, 0); step(0, 0, 4, 0); step(0, 0, 4, 0);
        // R8: flush with fetch and take
        cur = "R8";
        step(1, 4'hF, 0, 0); step(1, 4'hF, 2, 1); step(0, 0, 0, 0);
        check(disp_vld == '0, "R8 flushed", 32'(disp_vld), 0);
        // R9: simultaneous take and accept, random mix
        cur = "R9";
        for (int i = 0; i < 4000; i++)
            step(1'($urandom_range(0, 3) != 0), 4'($urandom), $urandom_range(0, 4),
                 1'($urandom_range(0, 60) == 0));
        step(0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule